// File: doc/BRIEF.md
# Two-Queue Egress Ratio Scheduler

This block sits in front of one egress port's transmitter and decides which of two transmit queues supplies the next frame. One queue holds high-priority traffic and the other holds low-priority traffic. The block receives a not-empty flag from each queue, a one-cycle pulse from the transmitter when the current frame has left, and two configuration inputs. The first is a two-bit scheduling mode. The second is a per-port split enable. For each frame the block raises a one-cycle grant and, in the same cycle, a queue select that says which queue must give up its head frame.

The mode picks one of four policies. The first is strict priority. The other three favour the high queue by a fixed whole-frame weight (10:1, 5:1 or 2:1). The block counts frames, not bytes. It never leaves a transmit slot unused while any queue it may serve holds a frame. When the split enable is low, the port behaves as a single queue. Only the high queue's flag counts, and the select always points at that queue.

A decision is taken only while no frame is in flight. After a grant, the block waits for the frame-done pulse before it considers the queues again. The grant and the select are registered.

Top module: `egress_ratio_sched`

## Requirements
- R1: After reset, `grant` is 0 and `qSelLow` is 0 (the high queue). The ratio count starts at zero, so with both queues backlogged in mode 2'b01 the first ten grants select the high queue.
- R2: When no frame is in flight and a servable queue is non-empty, `grant` is high for exactly one cycle, on the clock edge after the condition holds. No further grant occurs until `frameDone` has been sampled high. The next grant then follows on the edge after that sample.
- R3: In mode 2'b00 (strict), every grant selects the high queue (`qSelLow`=0) whenever `hiReady` is high.
- R4: In mode 2'b01, with both queues backlogged, the grants repeat a pattern of ten high-queue frames followed by one low-queue frame (`qSelLow`=1).
- R5: In mode 2'b10, with both queues backlogged, the grants repeat a pattern of five high-queue frames followed by one low-queue frame.
- R6: In mode 2'b11, with both queues backlogged, the grants repeat a pattern of two high-queue frames followed by one low-queue frame.
- R7: The block is work-conserving.
  - If the high queue is empty and the low queue is servable, the low queue is granted in any mode.
  - If the low queue is empty, the high queue is granted even when its weight is used up.
- R8: The ratio count changes at three points only.
  - It increases by one when `frameDone` ends a high-queue frame, and it stops at the mode's weight.
  - It clears when `frameDone` ends a low-queue frame.
  - It clears whenever `schedMode` changes, and the first decision in the new mode already sees a count of zero.
- R9: When `splitEn` is 0, `loReady` is ignored. Every grant selects the high queue, and no grant is issued while only `loReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hiReady | input | 1 | High-priority queue holds at least one frame |
| loReady | input | 1 | Low-priority queue holds at least one frame |
| frameDone | input | 1 | One-cycle pulse when the granted frame has finished transmitting |
| schedMode | input | 2 | 00 strict, 01 10:1, 10 5:1, 11 2:1 |
| splitEn | input | 1 | 1: two queues; 0: single (high) queue |
| grant | output | 1 | One-cycle pulse: start the next frame |
| qSelLow | output | 1 | Queue for the granted frame: 0 high, 1 low; valid with `grant` and held until the next one |

## Verification
From idle, a grant is due one clock edge after the queue flags are raised. After a frame ends, the next grant is due on the second edge after `frameDone` is driven: one edge retires the frame and the next one issues the grant. `qSelLow` carries its value in the same cycle as the grant. The bench drives inputs on falling edges and counts falling edges from each launch point. It fails any grant that does not arrive on the first falling edge after the launch. It also watches three falling edges inside every frame and fails a grant there. A monitor pops the expected queue choice only when it sees a grant, so the ratio pattern is compared one frame at a time.

// File: rtl/egsched_pkg.sv
package egsched_pkg;

  typedef enum logic [1:0] {
    SCHED_STRICT = 2'b00,
    SCHED_WT_A   = 2'b01,
    SCHED_WT_B   = 2'b10,
    SCHED_WT_C   = 2'b11
  } schedMode_e;

  // Strobes from the control FSM to the selection datapath
  typedef struct packed {
    logic issue;   // a frame is granted this cycle
    logic retire;  // the frame in flight has finished
  } schedStrobe_t;

endpackage

// File: rtl/egsched_ctrl.sv
module egsched_ctrl
  import egsched_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         eligible,
  input  logic         frameDone,
  output schedStrobe_t strobe,
  output logic         grant
);

  logic busy;

  always_comb begin
    strobe.issue  = !busy && eligible;
    strobe.retire = busy && frameDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      grant <= 1'b0;
    end else begin
      grant <= strobe.issue;
      if (strobe.issue)       busy <= 1'b1;
      else if (strobe.retire) busy <= 1'b0;
    end
  end

  // R2: a grant lasts a single cycle
  assert_grant_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    grant |=> !grant);

  // R2: no new grant while a frame is still in flight
  assert_no_midframe_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !frameDone) |=> !grant);

  // R1: the cycle after reset shows no grant
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> !grant);

endmodule

// File: rtl/egsched_path.sv
module egsched_path
  import egsched_pkg::*;
#(
  parameter int RATIO_A = 10,
  parameter int RATIO_B = 5,
  parameter int RATIO_C = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hiReady,
  input  logic         loReady,
  input  logic         splitEn,
  input  schedMode_e   mode,
  input  schedStrobe_t strobe,
  output logic         eligible,
  output logic         qSelLow
);

  localparam int RATIO_AB = (RATIO_A > RATIO_B) ? RATIO_A : RATIO_B;
  localparam int RATIO_MAX = (RATIO_AB > RATIO_C) ? RATIO_AB : RATIO_C;
  localparam int CNT_W = $clog2(RATIO_MAX + 1);

  logic [CNT_W-1:0] hiCount, cntEff, limit;
  schedMode_e modePrev;
  logic modeChange, loUsable, pickLow, holdZero;

  assign modeChange = (mode != modePrev);
  assign loUsable   = splitEn && loReady;
  assign eligible   = hiReady || loUsable;
  assign holdZero   = modeChange || !splitEn || (mode == SCHED_STRICT);
  assign cntEff     = holdZero ? '0 : hiCount;

  always_comb begin
    case (mode)
      SCHED_WT_A: limit = CNT_W'(RATIO_A);
      SCHED_WT_B: limit = CNT_W'(RATIO_B);
      SCHED_WT_C: limit = CNT_W'(RATIO_C);
      default:    limit = '0;
    endcase
  end

  always_comb begin
    if (!splitEn)                  pickLow = 1'b0;
    else if (!hiReady)             pickLow = loUsable;
    else if (mode == SCHED_STRICT) pickLow = 1'b0;
    else                           pickLow = loUsable && (cntEff >= limit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qSelLow  <= 1'b0;
      hiCount  <= '0;
      modePrev <= SCHED_STRICT;
    end else begin
      modePrev <= mode;
      if (strobe.issue) qSelLow <= pickLow;
      if (holdZero)                hiCount <= '0;
      else if (strobe.retire) begin
        if (qSelLow)               hiCount <= '0;
        else if (hiCount < limit)  hiCount <= hiCount + 1'b1;
      end
    end
  end

  // R3: strict mode never bypasses a waiting high frame
  assert_strict_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && mode == SCHED_STRICT && hiReady) |=> !qSelLow);

  // R9: single-queue ports always select the high queue
  assert_single_queue_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && !splitEn) |=> !qSelLow);

  // R7: empty high queue hands the slot to the low queue
  assert_work_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && !hiReady) |=> qSelLow);

  // R7: empty low queue hands the slot to the high queue
  assert_work_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issue && !loReady) |=> !qSelLow);

  // R8: the count never passes the largest weight
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    hiCount <= CNT_W'(RATIO_MAX));

  // R8: a finished low frame clears the count
  assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.retire && qSelLow) |=> (hiCount == '0));

endmodule

// File: rtl/egress_ratio_sched.sv
module egress_ratio_sched
  import egsched_pkg::*;
#(
  parameter int RATIO_A = 10,
  parameter int RATIO_B = 5,
  parameter int RATIO_C = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hiReady,
  input  logic       loReady,
  input  logic       frameDone,
  input  logic [1:0] schedMode,
  input  logic       splitEn,
  output logic       grant,
  output logic       qSelLow
);

  schedStrobe_t strobe;
  logic eligible;

  egsched_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .eligible  (eligible),
    .frameDone (frameDone),
    .strobe    (strobe),
    .grant     (grant)
  );

  egsched_path #(
    .RATIO_A (RATIO_A),
    .RATIO_B (RATIO_B),
    .RATIO_C (RATIO_C)
  ) path_i (
    .clk      (clk),
    .rstN     (rstN),
    .hiReady  (hiReady),
    .loReady  (loReady),
    .splitEn  (splitEn),
    .mode     (schedMode_e'(schedMode)),
    .strobe   (strobe),
    .eligible (eligible),
    .qSelLow  (qSelLow)
  );

endmodule

// File: tb/egress_ratio_sched_tb.sv
module egress_ratio_sched_tb_top;

  logic clk = 1'b0;
  logic rstN, hiReady, loReady, frameDone, splitEn, grant, qSelLow;
  logic [1:0] schedMode;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic  expQ[$];
  string tagQ[$];

  // reference model state
  int       mCnt = 0;
  logic [1:0] mPrev = 2'b00;

  always #2 clk = ~clk;  // 250 MHz

  egress_ratio_sched dut_i (
    .clk(clk), .rstN(rstN), .hiReady(hiReady), .loReady(loReady),
    .frameDone(frameDone), .schedMode(schedMode), .splitEn(splitEn),
    .grant(grant), .qSelLow(qSelLow)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int weightOf(input logic [1:0] m);
    case (m)
      2'b01:   return 10;
      2'b10:   return 5;
      2'b11:   return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic predictLow(input logic [1:0] m, input logic sp,
                                      input logic h, input logic l);
    if (!sp)          return 1'b0;
    else if (!h)      return 1'b1;
    else if (m == 0)  return 1'b0;
    else if (!l)      return 1'b0;
    else              return (mCnt >= weightOf(m));
  endfunction

  // Monitor: compares each grant against the scoreboard
  always @(negedge clk) begin
    if (rstN && grant) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected grant", 1, 0);
      end else begin
        automatic logic e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(qSelLow === e, t, int'(qSelLow), int'(e));
      end
    end
  end

  // Driver: one phase of nFrames with fixed queue flags
  task automatic runPhase(input logic [1:0] m, input logic sp, input logic h,
                          input logic l, input int nFrames, input string tag);
    logic sel;
    schedMode = m; splitEn = sp; hiReady = h; loReady = l;
    if (m != mPrev || !sp || m == 2'b00) mCnt = 0;
    mPrev = m;
    for (int i = 0; i < nFrames; i++) begin
      int k;
      sel = predictLow(m, sp, h, l);
      expQ.push_back(sel);
      tagQ.push_back(tag);
      k = 0;
      do begin
        @(negedge clk);
        k++;
      end while (!grant && k < 20);
      check(k == 1, "R2 grant latency", k, 1);
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        check(grant == 1'b0, "R2 no grant mid-frame", int'(grant), 0);
      end
      if (i == nFrames - 1) begin
        hiReady = 1'b0; loReady = 1'b0;
      end
      frameDone = 1'b1;
      @(negedge clk);
      frameDone = 1'b0;
      if (!sp || m == 2'b00 || sel) mCnt = 0;
      else if (mCnt < weightOf(m)) mCnt++;
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; hiReady = 1'b0; loReady = 1'b0; frameDone = 1'b0;
    schedMode = 2'b00; splitEn = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(grant == 1'b0, "R1 grant after reset", int'(grant), 0);
    check(qSelLow == 1'b0, "R1 select after reset", int'(qSelLow), 0);
    // R1 and R4: count starts at zero, 10:1 pattern twice
    runPhase(2'b01, 1'b1, 1'b1, 1'b1, 22, "R4 ratio 10:1");
    // R5: 5:1
    runPhase(2'b10, 1'b1, 1'b1, 1'b1, 12, "R5 ratio 5:1");
    // R6: 2:1
    runPhase(2'b11, 1'b1, 1'b1, 1'b1, 6, "R6 ratio 2:1");
    // R3: strict priority keeps serving high
    runPhase(2'b00, 1'b1, 1'b1, 1'b1, 5, "R3 strict");
    // R7: high empty, low served in strict mode
    runPhase(2'b00, 1'b1, 1'b0, 1'b1, 3, "R7 low when high empty");
    // R7: low empty, high served past its weight
    runPhase(2'b01, 1'b1, 1'b1, 1'b0, 4, "R7 high when low empty");
    // R8: mode change clears the count: five highs before the low
    runPhase(2'b10, 1'b1, 1'b1, 1'b1, 6, "R8 count cleared on mode change");
    // R8: count stops at weight, then low goes first
    runPhase(2'b11, 1'b1, 1'b1, 1'b0, 5, "R8 saturate high-only");
    runPhase(2'b11, 1'b1, 1'b1, 1'b1, 3, "R8 saturated count gives low");
    // R9: split off, only low flag set: nothing granted
    schedMode = 2'b11; splitEn = 1'b0; hiReady = 1'b0; loReady = 1'b1;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      check(grant == 1'b0, "R9 low flag ignored", int'(grant), 0);
    end
    loReady = 1'b0;
    // R9: split off, both flags set: high queue only
    runPhase(2'b11, 1'b0, 1'b1, 1'b1, 4, "R9 single queue");
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R2 missing grant", expQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule